// File: doc/BRIEF.md
# Serial Fast Command Encoder

This block turns short command requests from local timing logic into three-bit codes on one serial line that runs to a group of front-end chips. Four command types exist: a synchronising reset (resync), a bunch-crossing-zero marker (BC0), a calibration pulse request (cal) and a level-one trigger accept (L1A). Each code opens with a start bit at 1. Two code bits follow, most significant first. The line rests at 0 between codes.

Requests are single-cycle pulses on a four-bit vector, and the bit index is the command's code value. A request that cannot go out at once is held in a pending flag for its type. Whenever the line becomes free, a fixed priority order chooses the next code to send. A new code can start on the cycle right after the last bit of the previous one. Each type has one pending flag. A second request of a type that is still waiting merges with the first, and a lost pulse reports it. An acknowledge pulse marks the cycle in which a command's start bit is on the line.

The sequencer is a four-state machine. ST_IDLE holds the line low. ST_START drives the start bit and raises the acknowledge. ST_HI drives code bit 1. ST_LO drives code bit 0. The transitions are: ST_IDLE to ST_START when any request or pending flag is present; ST_START to ST_HI and ST_HI to ST_LO always; ST_LO to ST_START when work is waiting, otherwise ST_LO to ST_IDLE.

Top module: `fast_cmd_encoder`

## Requirements
- R1: After reset the serial line, every acknowledge bit and every lost bit are 0, and the line stays 0 while nothing is requested or pending.
- R2: Every command takes three consecutive cycles on the line: a 1, then code bit 1, then code bit 0. The codes are L1A = 00 (index 0), BC0 = 01 (index 1), resync = 10 (index 2) and cal = 11 (index 3), giving the serial patterns 100, 101, 110 and 111.
- R3: When the block is idle and a request is sampled at clock edge E, its start bit is on the line in the cycle that follows E.
- R4: Bit k of the acknowledge output is high for exactly one cycle, the cycle in which command k's start bit is driven. At most one acknowledge bit is high at a time.
- R5: When several commands are requested or pending at the moment the line becomes free, they are sent in the order resync, BC0, cal, L1A.
- R6: A request that arrives while a command is being sent is held and sent later. A code that is waiting starts on the cycle right after bit 0 of the previous code, with no idle cycle between them.
- R7: A request of type k that arrives while type k is already pending, and is not being chosen on that edge, is merged. Type k is then sent only once, and lost bit k is high for one cycle after the edge that sampled the extra request.
- R8: A request of type k that arrives on the edge at which the pending type k is chosen for sending is kept as a new pending request. That type is then sent twice, and no lost bit rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Request pulses, bit index = command code |
| ser_o | output | 1 | Serial command line, most significant bit first |
| ack_o | output | 4 | Start-bit acknowledge, one bit per command |
| lost_o | output | 4 | Merged-request flag, one bit per command |

## Verification
The hardest cases to reach are the two timing edges of a pending flag: a repeat request that arrives while the flag is still waiting (R7), and a repeat request that lands on the exact edge where the pending copy is chosen (R8). The bench gets there by first launching an L1A to keep the line busy. It then places the cal request and its repeat at cycle offsets counted from that launch: one cycle later for the merge case, and on the last bit of the L1A for the keep case. It also sweeps all sixteen combinations of simultaneous requests and checks the order and the start cycles of the codes.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
    localparam int NCMD   = 4;
    localparam int CODE_W = $clog2(NCMD);

    typedef enum logic [CODE_W-1:0] {
        CMD_L1A   = 2'd0,
        CMD_BC0   = 2'd1,
        CMD_RSYNC = 2'd2,
        CMD_CAL   = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_HI    = 2'd2,
        ST_LO    = 2'd3
    } seq_state_e;

    // highest priority first
    localparam cmd_e PRIO [NCMD] = '{CMD_RSYNC, CMD_BC0, CMD_CAL, CMD_L1A};
endpackage

// File: rtl/fcmd_pending.sv
module fcmd_pending
    import fcmd_pkg::*;
#(
    parameter int N = NCMD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] grant,
    output logic [N-1:0] pend_q,
    output logic [N-1:0] lost_q
);
    logic [N-1:0] pend_d;
    logic [N-1:0] lost_d;

    always_comb begin
        for (int k = 0; k < N; k++) begin
            lost_d[k] = pend_q[k] & req[k] & ~grant[k];
            pend_d[k] = grant[k] ? (pend_q[k] & req[k]) : (pend_q[k] | req[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            lost_q <= '0;
        end else begin
            pend_q <= pend_d;
            lost_q <= lost_d;
        end
    end

    generate
        for (genvar k = 0; k < N; k++) begin : g_chk
            AST_GRANT_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
                grant[k] |-> (pend_q[k] | req[k])); // R5
            AST_LOST_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
                lost_q[k] |-> pend_q[k]); // R7
        end
    endgenerate
endmodule

// File: rtl/fcmd_arbiter.sv
module fcmd_arbiter
    import fcmd_pkg::*;
(
    input  logic [NCMD-1:0] cand,
    output logic            valid,
    output cmd_e            sel,
    output logic [NCMD-1:0] grant
);
    always_comb begin
        valid = 1'b0;
        sel   = CMD_L1A;
        // walk from lowest to highest priority; the last hit wins
        for (int i = NCMD - 1; i >= 0; i--) begin
            if (cand[PRIO[i]]) begin
                valid = 1'b1;
                sel   = PRIO[i];
            end
        end
        grant = valid ? (NCMD'(1) << sel) : '0;
    end
endmodule

// File: rtl/fcmd_sequencer.sv
module fcmd_sequencer
    import fcmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  cmd_e            launch_cmd,
    output logic            free,
    output logic            ser_o,
    output logic [NCMD-1:0] ack_o
);
    seq_state_e state_q, state_d;
    cmd_e       cur_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch) state_d = ST_START;
            ST_START: state_d = ST_HI;
            ST_HI:    state_d = ST_LO;
            ST_LO:    state_d = launch ? ST_START : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= CMD_L1A;
        end else begin
            state_q <= state_d;
            if (launch && free) cur_q <= launch_cmd;
        end
    end

    always_comb begin
        free  = (state_q == ST_IDLE) || (state_q == ST_LO);
        ser_o = 1'b0;
        ack_o = '0;
        unique case (state_q)
            ST_IDLE:  ser_o = 1'b0;
            ST_START: begin
                ser_o = 1'b1;
                ack_o = NCMD'(1) << cur_q;
            end
            ST_HI:    ser_o = cur_q[1];
            ST_LO:    ser_o = cur_q[0];
        endcase
    end

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o)); // R4
    AST_ACK_GAP1: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |=> !(|ack_o)); // R2
    AST_ACK_GAP2: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |=> ##1 !(|ack_o)); // R2
endmodule

// File: rtl/fast_cmd_encoder.sv
module fast_cmd_encoder
    import fcmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCMD-1:0] req_i,
    output logic            ser_o,
    output logic [NCMD-1:0] ack_o,
    output logic [NCMD-1:0] lost_o
);
    logic [NCMD-1:0] pend_q;
    logic [NCMD-1:0] cand;
    logic [NCMD-1:0] arb_grant;
    logic [NCMD-1:0] grant;
    logic            arb_valid;
    logic            free;
    logic            take;
    cmd_e            arb_sel;

    assign cand  = pend_q | req_i;
    assign take  = free & arb_valid;
    assign grant = take ? arb_grant : '0;

    fcmd_pending #(.N(NCMD)) i_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_i),
        .grant  (grant),
        .pend_q (pend_q),
        .lost_q (lost_o)
    );

    fcmd_arbiter i_arbiter (
        .cand  (cand),
        .valid (arb_valid),
        .sel   (arb_sel),
        .grant (arb_grant)
    );

    fcmd_sequencer i_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (take),
        .launch_cmd (arb_sel),
        .free       (free),
        .ser_o      (ser_o),
        .ack_o      (ack_o)
    );

    AST_RSYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cand[CMD_RSYNC]) |-> (grant == 4'b0100)); // R5
    AST_LAUNCH_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (ser_o && (|ack_o))); // R3

    generate
        for (genvar k = 0; k < NCMD; k++) begin : g_code
            localparam logic B1 = 1'((k >> 1) & 1);
            localparam logic B0 = 1'(k & 1);
            AST_CODE_HI: assert property (@(posedge clk) disable iff (!rst_n)
                ack_o[k] |=> (ser_o == B1)); // R2
            AST_CODE_LO: assert property (@(posedge clk) disable iff (!rst_n)
                ack_o[k] |=> ##1 (ser_o == B0)); // R2
        end
    endgenerate
endmodule

// File: tb/test_fast_cmd_encoder.sv
module test_fast_cmd_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic       ser;
    logic [3:0] ack;
    logic [3:0] lost;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    int log_code [256];
    int log_cyc  [256];
    int log_n = 0;

    int ph = 0;
    int st_cyc = 0;
    int b1 = 0;
    logic [3:0] st_ack = '0;

    always #10ns clk = ~clk;

    fast_cmd_encoder i_fast_cmd_encoder (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req),
        .ser_o  (ser),
        .ack_o  (ack),
        .lost_o (lost)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", r, act, exp, cyc);
        end
    endtask

    // serial decoder, also checks acknowledge timing (R4)
    always @(negedge clk) begin
        if (rst_n) begin
            case (ph)
                0: begin
                    if (ser) begin
                        st_cyc = cyc;
                        st_ack = ack;
                        ph = 1;
                    end else begin
                        chk(ack == 4'b0, "R4 ack idle", int'(ack), 0);
                    end
                end
                1: begin
                    b1 = int'(ser);
                    chk(ack == 4'b0, "R4 ack bit1", int'(ack), 0);
                    ph = 2;
                end
                default: begin
                    chk(ack == 4'b0, "R4 ack bit0", int'(ack), 0);
                    log_code[log_n] = b1 * 2 + int'(ser);
                    log_cyc[log_n]  = st_cyc;
                    chk(st_ack == (4'b1 << log_code[log_n]), "R4 ack start",
                        int'(st_ack), 1 << log_code[log_n]);
                    log_n++;
                    ph = 0;
                end
            endcase
        end
    end

    // expected sequence check: codes exp[] starting at cycles st[]
    task automatic expect_log(input int base, input int n, input int codes[4],
                              input int starts[4], input string r);
        chk(log_n - base == n, {r, " count"}, log_n - base, n);
        for (int j = 0; j < n; j++) begin
            chk(log_code[base+j] == codes[j], {r, " code"}, log_code[base+j], codes[j]);
            chk(log_cyc[base+j] == starts[j], {r, " start"}, log_cyc[base+j], starts[j]);
        end
    endtask

    initial begin
        #3ms;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ord[4] = '{2, 1, 3, 0};
        int codes[4];
        int starts[4];
        int base, c, n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ser == 1'b0, "R1 reset ser", int'(ser), 0);
        chk(ack == 4'b0, "R1 reset ack", int'(ack), 0);
        chk(lost == 4'b0, "R1 reset lost", int'(lost), 0);
        repeat (4) @(negedge clk);
        chk(ser == 1'b0 && log_n == 0, "R1 idle line", log_n, 0);

        // R2 R3 R5: every mask of simultaneous requests
        for (int m = 0; m < 16; m++) begin
            base = log_n;
            c = cyc;
            req = 4'(m);
            @(negedge clk);
            req = '0;
            repeat (15) @(negedge clk);
            n = 0;
            for (int i = 0; i < 4; i++) begin
                if (m[ord[i]]) begin
                    codes[n]  = ord[i];
                    starts[n] = c + 1 + 3 * n;
                    n++;
                end
            end
            expect_log(base, n, codes, starts, "R5 R3 R2 sweep");
            chk(ser == 1'b0, "R1 line low after burst", int'(ser), 0);
        end

        // R6: requests arriving mid-transmission, sent back to back
        base = log_n;
        c = cyc;
        req = 4'b0001;
        @(negedge clk);
        req = 4'b0110;
        @(negedge clk);
        req = '0;
        repeat (12) @(negedge clk);
        codes  = '{0, 2, 1, 0};
        starts = '{c + 1, c + 4, c + 7, 0};
        expect_log(base, 3, codes, starts, "R6 held");

        // R7: repeat cal while cal is still pending -> merged, lost pulse
        base = log_n;
        c = cyc;
        req = 4'b0001;
        @(negedge clk);
        req = 4'b1000;
        @(negedge clk);
        req = 4'b1000;
        @(negedge clk);
        req = '0;
        chk(lost == 4'b1000, "R7 lost pulse", int'(lost), 8);
        @(negedge clk);
        chk(lost == 4'b0000, "R7 lost one cycle", int'(lost), 0);
        repeat (10) @(negedge clk);
        codes  = '{0, 3, 0, 0};
        starts = '{c + 1, c + 4, 0, 0};
        expect_log(base, 2, codes, starts, "R7 merged");

        // R8: repeat cal on the edge where pending cal is chosen -> kept
        base = log_n;
        c = cyc;
        req = 4'b0001;
        @(negedge clk);
        req = 4'b1000;
        @(negedge clk);
        req = '0;
        @(negedge clk);
        req = 4'b1000;
        @(negedge clk);
        req = '0;
        chk(lost == 4'b0000, "R8 no lost", int'(lost), 0);
        repeat (12) @(negedge clk);
        codes  = '{0, 3, 3, 0};
        starts = '{c + 1, c + 4, c + 7, 0};
        expect_log(base, 3, codes, starts, "R8 kept");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule